// File: doc/BRIEF.md
# SPI Host Read Transaction Sequencer

This block is the host side of a peripheral-initiated read on a serial link made of a clock, chip select, two data lines and an active-low interrupt line. While no transfer is in flight, the peripheral pulls the interrupt line low to announce that it has data. The sequencer then drives chip select low and clocks out a three-byte read command. From the bytes the peripheral returns next, it learns how long the payload is, and it clocks in exactly that many bytes.

Each received payload byte is handed to the host logic on a byte output with a one-cycle valid strobe, and a last flag marks the final byte. The block does not know the transfer length in advance, because it arrives inside the header. A busy output is high for as long as chip select is low, so that an external arbiter can order reads against pending writes. The serial clock idles low, the host shifts its output on the rising edge and samples the input on the falling edge, most significant bit first. The serial clock half period is HALF_DIV system clocks.

Top module: `spi_rd_seq`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, busy is 0 and rd_valid is 0.
- R2: A transfer starts (cs_n falls) only when irq_n is low while the block is idle and armed; while irq_n stays high, cs_n stays high.
- R3: The first three bytes sent on mosi are 0x03, 0x00, 0x00, most significant bit first, and every byte after them is 0x00.
- R4: sclk is low whenever cs_n is high; miso is sampled on the falling sclk edge, most significant bit first.
- R5: Bytes at positions 3 and 4 of the transfer (counting from 0) carry the payload length, high byte first; the length counts any pad byte, and exactly that many payload bytes are delivered.
- R6: Each payload byte appears on rd_data with a single-cycle rd_valid pulse, in the order received.
- R7: rd_last is high together with rd_valid exactly on the payload byte whose running count equals the latched length, and at no other time.
- R8: cs_n rises after the final byte, so the transfer has exactly 8*(5+length) falling sclk edges.
- R9: A length of zero ends the transfer after the five header bytes, with no rd_valid pulse.
- R10: After cs_n rises, no new transfer starts until irq_n has been seen high.
- R11: busy is high exactly while cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | Active-low request line from the peripheral |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the peripheral |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | High while a read holds the bus |
| rd_valid | output | 1 | One-cycle strobe for a received payload byte |
| rd_data | output | 8 | Received payload byte |
| rd_last | output | 1 | Marks the final payload byte |

## Verification
cs_n falls on the first clock edge at which an idle, armed block sees irq_n low. Each byte then takes 16*HALF_DIV clocks plus two handoff cycles, and rd_valid pulses in the cycle right after the register update for the eighth falling sclk edge of a payload byte. For the final byte, cs_n rises in that same cycle. Since these delays depend on the divider, the bench does not count fixed cycles. It waits on cs_n edges and compares every rd_valid pulse, on the falling system clock edge, against a queue of expected bytes filled before irq_n is lowered. Byte counts on mosi are checked once cs_n has risen, and the quiet interval that follows is watched for a spurious restart.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
    localparam int LEN_W     = 16;
    localparam int HDR_BYTES = 5;
    localparam int LEN_POS   = 3;
    localparam logic [7:0] CMD_RD = 8'h03;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEAD,
        ST_BODY,
        ST_REARM
    } rd_state_e;
endpackage

// File: rtl/spi_rd_shift.sv
module spi_rd_shift #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic       done_o,
    output logic [7:0] rx_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] div;
        logic [2:0]    bit_n;
        logic          sclk;
        logic          mosi;
        logic [7:0]    tx;
        logic [7:0]    rx;
        logic          done;
    } sh_t;

    sh_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (!r_q.busy) begin
            if (start_i) begin
                r_d.busy  = 1'b1;
                r_d.div   = '0;
                r_d.bit_n = '0;
                r_d.tx    = tx_i;
            end
        end else if (r_q.div == CW'(HALF_DIV - 1)) begin
            r_d.div  = '0;
            r_d.sclk = !r_q.sclk;
            if (!r_q.sclk) begin
                r_d.mosi = r_q.tx[7];
                r_d.tx   = {r_q.tx[6:0], 1'b0};
            end else begin
                r_d.rx    = {r_q.rx[6:0], miso_i};
                r_d.bit_n = r_q.bit_n + 3'd1;
                if (r_q.bit_n == 3'd7) begin
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                end
            end
        end else begin
            r_d.div = r_q.div + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sclk_o = r_q.sclk;
    assign mosi_o = r_q.mosi;
    assign done_o = r_q.done;
    assign rx_o   = r_q.rx;

    // R3: the sequencer only asks for a byte when the shifter is free
    p_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !r_q.busy);

    // R8: byte completion is a single-cycle event
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);
endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
    import spi_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_n_i,
    input  logic       done_i,
    input  logic [7:0] rx_i,
    output logic       start_o,
    output logic [7:0] tx_o,
    output logic       cs_n_o,
    output logic       busy_o,
    output logic       rd_valid_o,
    output logic [7:0] rd_data_o,
    output logic       rd_last_o
);
    typedef struct packed {
        rd_state_e        st;
        logic [2:0]       hidx;
        logic [7:0]       len_hi;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] cnt;
        logic             cs_n;
        logic             go;
        logic [7:0]       tx;
        logic             valid;
        logic [7:0]       data;
        logic             last;
    } ct_t;

    ct_t r_q, r_d;
    logic [LEN_W-1:0] len_new;
    logic [LEN_W-1:0] cnt_inc;

    assign len_new = LEN_W'({r_q.len_hi, rx_i});
    assign cnt_inc = r_q.cnt + LEN_W'(1);

    always_comb begin
        r_d       = r_q;
        r_d.go    = 1'b0;
        r_d.valid = 1'b0;
        r_d.last  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (!irq_n_i) begin
                    r_d.st   = ST_HEAD;
                    r_d.cs_n = 1'b0;
                    r_d.hidx = '0;
                    r_d.go   = 1'b1;
                    r_d.tx   = CMD_RD;
                end
            end
            ST_HEAD: begin
                if (done_i) begin
                    r_d.hidx = r_q.hidx + 3'd1;
                    r_d.tx   = 8'h00;
                    if (r_q.hidx == 3'(LEN_POS)) r_d.len_hi = rx_i;
                    if (r_q.hidx == 3'(HDR_BYTES - 1)) begin
                        r_d.len = len_new;
                        r_d.cnt = '0;
                        if (len_new == '0) begin
                            r_d.st   = ST_REARM;
                            r_d.cs_n = 1'b1;
                        end else begin
                            r_d.st = ST_BODY;
                            r_d.go = 1'b1;
                        end
                    end else begin
                        r_d.go = 1'b1;
                    end
                end
            end
            ST_BODY: begin
                if (done_i) begin
                    r_d.valid = 1'b1;
                    r_d.data  = rx_i;
                    r_d.cnt   = cnt_inc;
                    if (cnt_inc == r_q.len) begin
                        r_d.last = 1'b1;
                        r_d.st   = ST_REARM;
                        r_d.cs_n = 1'b1;
                    end else begin
                        r_d.go = 1'b1;
                    end
                end
            end
            default: begin
                if (irq_n_i) r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign start_o    = r_q.go;
    assign tx_o       = r_q.tx;
    assign cs_n_o     = r_q.cs_n;
    assign busy_o     = !r_q.cs_n;
    assign rd_valid_o = r_q.valid;
    assign rd_data_o  = r_q.data;
    assign rd_last_o  = r_q.last;

    // R2: chip select only falls after irq_n was low
    p_cs_fall_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.cs_n) |-> $past(!irq_n_i));

    // R7: the last flag never appears without a byte
    p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.last |-> r_q.valid);

    // R6: bytes other than the final one arrive while the bus is held
    p_mid_valid_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.valid && !r_q.last) |-> !r_q.cs_n);

    // R10: a lingering low request does not restart a read
    p_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_REARM && !irq_n_i) |=> r_q.cs_n);
endmodule

// File: rtl/spi_rd_seq.sv
module spi_rd_seq #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_n,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       cs_n,
    output logic       busy,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       rd_last
);
    logic       start_w;
    logic [7:0] tx_w;
    logic       done_w;
    logic [7:0] rx_w;

    spi_rd_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_n_i    (irq_n),
        .done_i     (done_w),
        .rx_i       (rx_w),
        .start_o    (start_w),
        .tx_o       (tx_w),
        .cs_n_o     (cs_n),
        .busy_o     (busy),
        .rd_valid_o (rd_valid),
        .rd_data_o  (rd_data),
        .rd_last_o  (rd_last)
    );

    spi_rd_shift #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_w),
        .tx_i    (tx_w),
        .miso_i  (miso),
        .sclk_o  (sclk),
        .mosi_o  (mosi),
        .done_o  (done_w),
        .rx_o    (rx_w)
    );

    // R4: serial clock rests low whenever the bus is released
    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
endmodule

// File: tb/sim_spi_rd_seq.sv
module sim_spi_rd_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_n = 1'b1;
    logic       miso = 1'b0;
    logic       sclk, mosi, cs_n, busy, rd_valid, rd_last;
    logic [7:0] rd_data;

    int checks = 0;
    int errs = 0;
    bit done_flag = 1'b0;

    logic [8:0] exp_q[$];
    logic [7:0] sl_tx[0:63];
    logic [7:0] sl_rx[0:63];
    int sl_txi = 0;
    int sl_bit = 7;
    int sl_rxbits = 0;
    logic [7:0] sl_sh = 8'h00;

    always #(CLK_PERIOD / 2) clk = !clk;

    spi_rd_seq u0 (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .miso(miso),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // peripheral model: drives on rising edge, samples host data on falling edge
    always @(posedge sclk) begin
        if (!cs_n) begin
            miso = sl_tx[sl_txi][sl_bit];
            if (sl_bit == 0) begin
                sl_bit = 7;
                sl_txi++;
            end else begin
                sl_bit--;
            end
        end
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            sl_sh = {sl_sh[6:0], mosi};
            sl_rxbits++;
            if (sl_rxbits % 8 == 0) sl_rx[sl_rxbits / 8 - 1] = sl_sh;
        end
    end

    // monitor: every delivered byte is popped and compared (R5, R6, R7, R9)
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected byte", {23'd0, rd_last, rd_data}, 32'h0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e[7:0], "R6 payload byte", rd_data, e[7:0]);
                chk(rd_last == e[8], "R7 last flag", rd_last, e[8]);
            end
        end
    end

    task automatic do_read(input int len, input logic [7:0] seed);
        sl_tx[0] = 8'hA5;
        sl_tx[1] = 8'h3C;
        sl_tx[2] = 8'hFF;
        sl_tx[3] = 8'(len >> 8);
        sl_tx[4] = 8'(len);
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = seed + 8'(i * 37);
            sl_tx[5 + i] = b;
            exp_q.push_back({(i == len - 1), b});
        end
        sl_tx[5 + len] = 8'hEE;
        sl_txi = 0;
        sl_bit = 7;
        sl_rxbits = 0;
        @(negedge clk);
        irq_n = 1'b0;
        wait (cs_n == 1'b0);
        @(negedge clk);
        chk(busy == 1'b1, "R11 busy while selected", busy, 1);
        wait (cs_n == 1'b1);
        @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R11 busy after release", busy, 0);
        chk(sl_rxbits == 8 * (5 + len), len == 0 ? "R9 falling edges" : "R8 falling edges",
            sl_rxbits, 8 * (5 + len));
        chk(sl_rx[0] == 8'h03, "R3 opcode byte", sl_rx[0], 8'h03);
        chk(sl_rx[1] == 8'h00 && sl_rx[2] == 8'h00, "R3 command pad bytes",
            {sl_rx[1], sl_rx[2]}, 0);
        for (int i = 3; i < 5 + len; i++) begin
            if (sl_rx[i] != 8'h00) chk(1'b0, "R3 idle fill", sl_rx[i], 0);
        end
        chk(exp_q.size() == 0, "R5 payload count", exp_q.size(), 0);
        // irq_n still low: no restart allowed
        repeat (200) begin
            @(negedge clk);
            if (cs_n != 1'b1) chk(1'b0, "R10 restart without rearm", cs_n, 1);
        end
        chk(cs_n == 1'b1, "R10 held off", cs_n, 1);
        irq_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            sl_tx[i] = 8'h00;
            sl_rx[i] = 8'h00;
        end
        repeat (5) @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n reset", cs_n, 1);
        chk(sclk == 1'b0, "R1 sclk reset", sclk, 0);
        chk(busy == 1'b0 && rd_valid == 1'b0, "R1 busy/valid reset", {busy, rd_valid}, 0);
        rst_n = 1'b1;
        repeat (100) begin
            @(negedge clk);
            if (cs_n != 1'b1) chk(1'b0, "R2 start without request", cs_n, 1);
        end
        chk(cs_n == 1'b1 && sclk == 1'b0, "R2 R4 idle bus", {cs_n, sclk}, 2'b10);
        do_read(4, 8'h81);
        do_read(1, 8'hC3);
        do_read(0, 8'h00);
        do_read(7, 8'h5A);
        do_read(12, 8'h0F);
        do_read(260 % 16, 8'hF0);
        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule